// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns a segment value and an offset into a 32-bit linear address. It works in one of two modes, chosen per request. In paragraph mode the segment value is a 16-bit paragraph number. The block shifts it left by four bits and adds the low 16 bits of the offset. The sum is kept to 20 bits, which covers 1 MB.

In segment-base mode the caller supplies a 32-bit base and a 20-bit limit, already decoded. The block adds the full 32-bit offset to the base. It also checks the offset against the limit. Loading the base and limit from memory, privilege rules and page translation are all done outside this block.

A request is presented together with its operands for one cycle. The result appears on registered outputs on the next cycle. A request in segment-base mode whose offset is past the limit gives a fault pulse instead of a valid pulse.

Top module: `seg_linear_addr`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `valid_o`, `limit_fault_o` and `lin_addr_o` are all zero.
- R2: A request with `prot_mode_i`=0 gives `lin_addr_o` = ({`seg_para_i`,4'b0000} + `offset_i[15:0]`) mod 2^20, and bits 31:20 of `lin_addr_o` are zero.
- R3: In paragraph mode, `offset_i[31:16]`, `seg_base_i` and `seg_limit_i` have no effect on the result.
- R4: In paragraph mode, a sum past 0xFFFFF wraps inside 20 bits (for example, paragraph 0xFFFF with offset 0xFFFF gives 0x0FFEF).
- R5: A request with `prot_mode_i`=1 and `offset_i` <= `seg_limit_i` gives `lin_addr_o` = `seg_base_i` + `offset_i` mod 2^32 and `valid_o`=1.
- R6: A request with `prot_mode_i`=1 and `offset_i` > `seg_limit_i` (the limit zero-extended to 32 bits) gives `limit_fault_o`=1 and `valid_o`=0, and `lin_addr_o` keeps its previous value. An offset equal to the limit is accepted.
- R7: Each result appears exactly one clock after the request. A cycle with `req_i`=0 gives `valid_o`=0 and `limit_fault_o`=0 on the next cycle, and `lin_addr_o` holds its value. `valid_o` and `limit_fault_o` are never high together.
- R8: A paragraph-mode request never raises `limit_fault_o`.
- R9: In segment-base mode, a base plus offset past 2^32-1 wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, one cycle per address |
| prot_mode_i | input | 1 | 0 = paragraph mode, 1 = segment-base mode |
| seg_para_i | input | 16 | Paragraph number (paragraph mode) |
| seg_base_i | input | 32 | Decoded segment base (segment-base mode) |
| seg_limit_i | input | 20 | Decoded segment limit, byte units (segment-base mode) |
| offset_i | input | 32 | Effective offset; only bits 15:0 are used in paragraph mode |
| lin_addr_o | output | 32 | Registered linear address |
| valid_o | output | 1 | Registered pulse: address formed |
| limit_fault_o | output | 1 | Registered pulse: offset beyond limit |

## Verification
Several properties are checked by assertions on every cycle:
- `valid_o` and `limit_fault_o` are never high together.
- Every pulse on either output traces back to a request one cycle earlier.
- A fault only follows a segment-base request whose offset was over its limit.
- Paragraph-mode results never have bits above 19 set.
- The address holds steady across a fault.

The exact sums can only be shown by the bench's directed scenarios. These include the 20-bit and 32-bit wraps, the offset-equals-limit and limit-plus-one boundary, the fact that unused inputs in paragraph mode have no effect, and back-to-back requests that switch mode.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    typedef enum logic {
        MODE_PARA = 1'b0,
        MODE_BASE = 1'b1
    } seg_mode_e;

    localparam int SEG_W_DEF   = 16;
    localparam int SHIFT_DEF   = 4;
    localparam int ADDR_W_DEF  = 32;
    localparam int LIMIT_W_DEF = 20;
    localparam int OFS_W_DEF   = 32;

endpackage

// File: rtl/seg_para_unit.sv
module seg_para_unit #(
    parameter int SEG_W  = 16,
    parameter int SHIFT  = 4,
    parameter int OFS_W  = 32,
    parameter int ADDR_W = 32
) (
    input  logic [SEG_W-1:0]  para_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int REAL_W = SEG_W + SHIFT;

    logic [REAL_W-1:0] para_shifted;
    logic [REAL_W-1:0] ofs_ext;
    logic [REAL_W-1:0] sum;

    always_comb begin
        para_shifted = {para_i, {SHIFT{1'b0}}};
        ofs_ext      = REAL_W'(offset_i[SEG_W-1:0]);
        sum          = para_shifted + ofs_ext;
        addr_o       = ADDR_W'(sum);
    end

endmodule

// File: rtl/seg_base_unit.sv
module seg_base_unit #(
    parameter int ADDR_W  = 32,
    parameter int LIMIT_W = 20,
    parameter int OFS_W   = 32
) (
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic [OFS_W-1:0]   offset_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               over_o
);
    logic [OFS_W-1:0] limit_ext;

    always_comb begin
        limit_ext = OFS_W'(limit_i);
        addr_o    = base_i + ADDR_W'(offset_i);
        over_o    = offset_i > limit_ext;
    end

endmodule

// File: rtl/seg_linear_addr.sv
module seg_linear_addr
    import seg_addr_pkg::*;
#(
    parameter int SEG_W   = SEG_W_DEF,
    parameter int SHIFT   = SHIFT_DEF,
    parameter int ADDR_W  = ADDR_W_DEF,
    parameter int LIMIT_W = LIMIT_W_DEF,
    parameter int OFS_W   = OFS_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic               prot_mode_i,
    input  logic [SEG_W-1:0]   seg_para_i,
    input  logic [ADDR_W-1:0]  seg_base_i,
    input  logic [LIMIT_W-1:0] seg_limit_i,
    input  logic [OFS_W-1:0]   offset_i,
    output logic [ADDR_W-1:0]  lin_addr_o,
    output logic               valid_o,
    output logic               limit_fault_o
);
    localparam int REAL_W = SEG_W + SHIFT;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic              fault;
    } gen_state_t;

    gen_state_t state_d, state_q;

    logic [ADDR_W-1:0] para_addr;
    logic [ADDR_W-1:0] base_addr;
    logic              base_over;
    seg_mode_e         mode;

    seg_para_unit #(
        .SEG_W (SEG_W),
        .SHIFT (SHIFT),
        .OFS_W (OFS_W),
        .ADDR_W(ADDR_W)
    ) u_para (
        .para_i  (seg_para_i),
        .offset_i(offset_i),
        .addr_o  (para_addr)
    );

    seg_base_unit #(
        .ADDR_W (ADDR_W),
        .LIMIT_W(LIMIT_W),
        .OFS_W  (OFS_W)
    ) u_base (
        .base_i  (seg_base_i),
        .limit_i (seg_limit_i),
        .offset_i(offset_i),
        .addr_o  (base_addr),
        .over_o  (base_over)
    );

    always_comb begin
        mode          = seg_mode_e'(prot_mode_i);
        state_d       = state_q;
        state_d.valid = 1'b0;
        state_d.fault = 1'b0;
        if (req_i) begin
            if (mode == MODE_PARA) begin
                state_d.addr  = para_addr;
                state_d.valid = 1'b1;
            end else if (base_over) begin
                state_d.fault = 1'b1;
            end else begin
                state_d.addr  = base_addr;
                state_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign lin_addr_o    = state_q.addr;
    assign valid_o       = state_q.valid;
    assign limit_fault_o = state_q.fault;

    // R7: the two result pulses never coincide
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && limit_fault_o));

    // R7: every pulse is caused by a request one cycle earlier
    a_r7_pulse_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || limit_fault_o) |-> $past(req_i));

    // R8: paragraph-mode requests never fault
    a_r8_para_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_i && !prot_mode_i) |-> !limit_fault_o);

    // R6: a fault needs an over-limit segment-base request
    a_r6_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        limit_fault_o |-> $past(prot_mode_i && (offset_i > OFS_W'(seg_limit_i))));

    // R6: the address register holds across a fault
    a_r6_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        limit_fault_o |-> $stable(lin_addr_o));

    // R2: paragraph results stay below 2^REAL_W
    a_r2_para_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(!prot_mode_i)) |-> (lin_addr_o[ADDR_W-1:REAL_W] == '0));

endmodule

// File: tb/seg_linear_addr_tb.sv
`timescale 1ns/1ps
module seg_linear_addr_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i;
    logic        prot_mode_i;
    logic [15:0] seg_para_i;
    logic [31:0] seg_base_i;
    logic [19:0] seg_limit_i;
    logic [31:0] offset_i;
    logic [31:0] lin_addr_o;
    logic        valid_o;
    logic        limit_fault_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    seg_linear_addr u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .prot_mode_i  (prot_mode_i),
        .seg_para_i   (seg_para_i),
        .seg_base_i   (seg_base_i),
        .seg_limit_i  (seg_limit_i),
        .offset_i     (offset_i),
        .lin_addr_o   (lin_addr_o),
        .valid_o      (valid_o),
        .limit_fault_o(limit_fault_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_in(input logic pm, input logic [15:0] para, input logic [31:0] base,
                          input logic [19:0] lim, input logic [31:0] ofs);
        prot_mode_i = pm;
        seg_para_i  = para;
        seg_base_i  = base;
        seg_limit_i = lim;
        offset_i    = ofs;
    endtask

    // one request, outputs sampled at the following negedge
    task automatic issue(input logic pm, input logic [15:0] para, input logic [31:0] base,
                         input logic [19:0] lim, input logic [31:0] ofs);
        @(negedge clk);
        set_in(pm, para, base, lim, ofs);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic t_reset();
        req_i = 0;
        set_in(0, 16'h0, 32'h0, 20'h0, 32'h0);
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(valid_o), 0);
        chk("R1 fault in reset", 32'(limit_fault_o), 0);
        chk("R1 addr in reset", lin_addr_o, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(valid_o), 0);
        chk("R1 addr after reset", lin_addr_o, 0);
    endtask

    task automatic t_para_basic();
        issue(0, 16'h1234, 32'h0, 20'h0, 32'h0000_0022);
        chk("R2 para addr", lin_addr_o, 32'h0001_2362);
        chk("R2 para valid", 32'(valid_o), 1);
        chk("R8 para no fault", 32'(limit_fault_o), 0);
        issue(0, 16'hF000, 32'h0, 20'h0, 32'h0000_FFF0);
        chk("R2 para top", lin_addr_o, 32'h000F_FFF0);
    endtask

    task automatic t_para_ignore();
        issue(0, 16'h0100, 32'hFFFF_FFFF, 20'h00000, 32'hABCD_0010);
        chk("R3 para ignores unused", lin_addr_o, 32'h0000_1010);
        chk("R3 para valid", 32'(valid_o), 1);
        chk("R8 para big offset no fault", 32'(limit_fault_o), 0);
    endtask

    task automatic t_para_wrap();
        issue(0, 16'hFFFF, 32'h0, 20'h0, 32'h0000_FFFF);
        chk("R4 para wrap", lin_addr_o, 32'h0000_FFEF);
        chk("R4 para wrap valid", 32'(valid_o), 1);
    endtask

    task automatic t_base_basic();
        issue(1, 16'hFFFF, 32'h0010_0000, 20'hFFFFF, 32'h0000_1234);
        chk("R5 base addr", lin_addr_o, 32'h0010_1234);
        chk("R5 base valid", 32'(valid_o), 1);
        chk("R5 base no fault", 32'(limit_fault_o), 0);
    endtask

    task automatic t_base_limit();
        issue(1, 16'h0, 32'h0200_0000, 20'h00FFF, 32'h0000_0FFF);
        chk("R6 at limit addr", lin_addr_o, 32'h0200_0FFF);
        chk("R6 at limit valid", 32'(valid_o), 1);
        issue(1, 16'h0, 32'h0200_0000, 20'h00FFF, 32'h0000_1000);
        chk("R6 over limit fault", 32'(limit_fault_o), 1);
        chk("R6 over limit valid", 32'(valid_o), 0);
        chk("R6 over limit addr held", lin_addr_o, 32'h0200_0FFF);
        issue(1, 16'h0, 32'h0, 20'hFFFFF, 32'h0010_0000);
        chk("R6 offset above 20 bits fault", 32'(limit_fault_o), 1);
    endtask

    task automatic t_base_wrap();
        issue(1, 16'h0, 32'hFFFF_F000, 20'hFFFFF, 32'h0000_2000);
        chk("R9 base wrap", lin_addr_o, 32'h0000_1000);
        chk("R9 base wrap valid", 32'(valid_o), 1);
    endtask

    task automatic t_idle_and_b2b();
        issue(0, 16'h0001, 32'h0, 20'h0, 32'h0000_0001);
        @(negedge clk);
        chk("R7 idle valid low", 32'(valid_o), 0);
        chk("R7 idle fault low", 32'(limit_fault_o), 0);
        chk("R7 idle addr held", lin_addr_o, 32'h0000_0011);
        @(negedge clk);
        set_in(1, 16'h0, 32'h0000_4000, 20'h000FF, 32'h0000_0010);
        req_i = 1;
        @(negedge clk);
        chk("R7 b2b first", lin_addr_o, 32'h0000_4010);
        set_in(0, 16'h0002, 32'h0, 20'h0, 32'h0000_0003);
        @(negedge clk);
        chk("R7 b2b second", lin_addr_o, 32'h0000_0023);
        chk("R7 b2b second valid", 32'(valid_o), 1);
        req_i = 0;
        @(negedge clk);
        chk("R7 b2b drop", 32'(valid_o), 0);
    endtask

    initial begin
        t_reset();
        t_para_basic();
        t_para_ignore();
        t_para_wrap();
        t_base_basic();
        t_base_limit();
        t_base_wrap();
        t_idle_and_b2b();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule